// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Code Register

This block holds the digital code for a 12-bit parallel-input converter. It has two storage stages in series: a front register that takes a word from the data bus, and a converter register that passes the held word to the analog side. The front register can be filled at any time while the converter keeps its current code. A separate load control then moves the new code to the converter, so the analog output changes only when it is told to.

Both stages are modelled as level-transparent latches. A system clock samples the control levels on each rising edge. When a write and a load are active in the same cycle, the bus word passes straight through to the converter code. The front register can be read back over the bus. An active-low reset, asynchronous to the clock, forces both stages to zero-scale or to mid-scale, chosen by a select input. The data bus is split into an input half, an output half and an output enable. The chip-level pad logic joins them into one bidirectional bus.

Top module: `dbuf_dac_reg`

## Requirements
- R1: While `rstN` is low, both stages hold the preset code, with no clock edge needed. The preset is 12'h000 when `rstSelMid` is 0 and 12'h800 (bit 11 set) when it is 1. Reset overrides every other control.
- R2: A rising clock edge with `csN`=0 and `rwN`=0 stores `dataIn` in the front register. The stored word shows on `dataOut` from the next cycle.
- R3: A rising clock edge with `loadN`=0 copies the front register into `dacCode`.
- R4: A rising clock edge with `csN`=0, `rwN`=0 and `loadN`=0 puts `dataIn` on `dacCode` in the next cycle (flow-through).
- R5: While `csN`=0 and `rwN`=1 (read), `dataOe` is 1 in the same cycle and `dataOut` carries the front register. A read leaves the front register unchanged.
- R6: When `loadN`=1 and either `csN`=1 or `rwN`=1, both stages keep their values.
- R7: `dataOe` is 0 whenever `csN`=1, `rwN`=0 or `rstN`=0.
- R8: `codeUpdated` is 1 for exactly the cycle after an edge on which `dacCode` took a different value. A load of an equal value gives no pulse, and reset never raises it.
- R9: After reset is released, both stages keep the preset code until a write or a load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rstSelMid | input | 1 | Reset target: 0 = zero-scale, 1 = mid-scale |
| csN | input | 1 | Chip select, active low |
| rwN | input | 1 | 1 = read the front register, 0 = write it |
| loadN | input | 1 | Converter register load, active low |
| dataIn | input | 12 | Bus word driven toward the block |
| dataOut | output | 12 | Front register word for readback |
| dataOe | output | 1 | Bus drive enable for readback |
| dacCode | output | 12 | Code sent to the converter |
| codeUpdated | output | 1 | One-cycle pulse after a change of `dacCode` |

## Verification
The bound checker checks these rules on every cycle:
- A write lands in the front register.
- Flow-through and load-only transfers reach `dacCode`.
- The code stays put when nothing selects it.
- The bus enable stays off outside a read.
- The update pulse appears only with a real change of code.

Some behaviour shows only in the bench's scenarios:
- The reset value is taken without a clock edge, in the middle of a cycle.
- The mid-scale and zero-scale presets survive reset release until the first write or load.
- An equal-value load gives no pulse.

A behavioural model is compared on every cycle across a long pseudo-random run of control and data patterns.

// File: rtl/dac_reg_pkg.sv
package dac_reg_pkg;
  // Strobes from control decode to the datapath
  typedef struct packed {
    logic wrIn;   // front register transparent this cycle
    logic ldDac;  // converter register transparent this cycle
    logic rdBus;  // readback drive enable
  } strobe_t;
endpackage

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
  import dac_reg_pkg::*;
(
  input  logic    rstN,
  input  logic    csN,
  input  logic    rwN,
  input  logic    loadN,
  output strobe_t strobes
);
  always_comb begin
    strobes.wrIn  = !csN && !rwN;
    strobes.ldDac = !loadN;
    strobes.rdBus = rstN && !csN && rwN;
  end
endmodule

// File: rtl/dac_reg_dpath.sv
module dac_reg_dpath
  import dac_reg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstSelMid,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] inRegQ,
  output logic [DATA_W-1:0] dacRegQ,
  output logic              updQ
);
  localparam logic [DATA_W-1:0] MID_CODE  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ZERO_CODE = '0;

  logic [DATA_W-1:0] presetCode;
  logic [DATA_W-1:0] dacNext;

  always_comb begin
    presetCode = rstSelMid ? MID_CODE : ZERO_CODE;
    // both latches open: bus flows through to the converter stage
    dacNext    = strobes.wrIn ? dataIn : inRegQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inRegQ  <= presetCode;
      dacRegQ <= presetCode;
      updQ    <= 1'b0;
    end else begin
      if (strobes.wrIn)  inRegQ  <= dataIn;
      if (strobes.ldDac) dacRegQ <= dacNext;
      updQ <= strobes.ldDac && (dacNext != dacRegQ);
    end
  end
endmodule

// File: rtl/dbuf_dac_reg.sv
module dbuf_dac_reg
  import dac_reg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstSelMid,
  input  logic              csN,
  input  logic              rwN,
  input  logic              loadN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] dacCode,
  output logic              codeUpdated
);
  strobe_t strobes;

  dac_reg_ctrl u_ctrl (
    .rstN    (rstN),
    .csN     (csN),
    .rwN     (rwN),
    .loadN   (loadN),
    .strobes (strobes)
  );

  dac_reg_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .rstSelMid (rstSelMid),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .inRegQ    (dataOut),
    .dacRegQ   (dacCode),
    .updQ      (codeUpdated)
  );

  assign dataOe = strobes.rdBus;
endmodule

// File: rtl/dac_reg_sva.sv
module dac_reg_sva #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              rstSelMid,
  input logic              csN,
  input logic              rwN,
  input logic              loadN,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic [DATA_W-1:0] dacCode,
  input logic              codeUpdated
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  assert_write_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rwN) |=> (dataOut == $past(dataIn)));

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && (csN || rwN)) |=> (dacCode == $past(dataOut)));

  assert_flow_through_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rwN && !loadN) |=> (dacCode == $past(dataIn)));

  assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rwN) |=> $stable(dataOut));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && (csN || rwN)) |=> ($stable(dacCode) && $stable(dataOut)));

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !rwN) |-> !dataOe);

  assert_pulse_real_R8: assert property (@(posedge clk) disable iff (!rstN)
    codeUpdated |-> (dacCode != $past(dacCode)));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!codeUpdated && !dataOe);
      assert_reset_preset_R1: assert (dacCode == (rstSelMid ? MID_CODE : '0));
    end
  end
endmodule

bind dbuf_dac_reg dac_reg_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/dbuf_dac_reg_tb.sv
module dbuf_dac_reg_tb;
  localparam int W = 12;
  localparam time HALF = 10ns;

  logic clk = 0, rstN = 1, rstSelMid = 0, csN = 1, rwN = 1, loadN = 1;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut, dacCode;
  logic dataOe, codeUpdated;

  int nCmp = 0, nBad = 0;
  int mIn = 0, mDac = 0;
  bit mUpd = 0;

  always #HALF clk = ~clk;

  dbuf_dac_reg #(.DATA_W(W)) u_dut (.*);

  // behavioural reference
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIn = rstSelMid ? 'h800 : 0; mDac = mIn; mUpd = 0;
    end else begin
      int nd;
      nd = mDac;
      if (!loadN) nd = (!csN && !rwN) ? int'(dataIn) : mIn;
      if (!csN && !rwN) mIn = dataIn;
      mUpd = (nd != mDac);
      mDac = nd;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(HALF/2);
    chk("R3/R4/R6 dacCode", dacCode, mDac);
    chk("R8 codeUpdated", codeUpdated, mUpd);
    chk("R5/R7 dataOe", dataOe, (rstN && !csN && rwN));
    if (dataOe) chk("R5 dataOut", dataOut, mIn);
  end

  task automatic step(bit c, bit r, bit l, logic [W-1:0] d);
    @(negedge clk);
    csN = c; rwN = r; loadN = l; dataIn = d;
    @(posedge clk);
    #(HALF/2 + 1);
  endtask

  initial begin
    #(200000 * 2 * HALF);
    nBad++; nCmp++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int lfsr;
    #1 rstN = 0;
    #2 chk("R1 zero preset", dacCode, 0);
    step(1, 1, 1, 'hFFF);
    chk("R7 no drive in reset", dataOe, 0);
    @(negedge clk); rstN = 1;
    step(1, 1, 1, 'h3C3);
    chk("R9 preset kept", dacCode, 0);
    step(0, 0, 1, 'hA5C);
    chk("R6 load high holds", dacCode, 0);
    chk("R7 no drive on write", dataOe, 0);
    step(0, 1, 1, 'h000);
    chk("R2 written word", dataOut, 'hA5C);
    chk("R5 read enables", dataOe, 1);
    step(1, 1, 0, 'h000);
    chk("R3 load copies", dacCode, 'hA5C);
    chk("R8 pulse on change", codeUpdated, 1);
    step(1, 1, 0, 'h000);
    chk("R8 no pulse same value", codeUpdated, 0);
    step(0, 0, 0, 'h123);
    chk("R4 flow-through", dacCode, 'h123);
    step(1, 0, 1, 'h777);
    chk("R6 deselected hold", dacCode, 'h123);
    // mid-cycle reset to mid-scale
    @(negedge clk); #3;
    rstSelMid = 1; rstN = 0;
    #1 chk("R1 async mid preset", dacCode, 'h800);
    step(1, 1, 1, 'h000);
    chk("R8 no pulse in reset", codeUpdated, 0);
    @(negedge clk); rstN = 1;
    step(0, 1, 1, 'h000);
    chk("R9 mid readback", dataOut, 'h800);
    chk("R9 mid code kept", dacCode, 'h800);
    // pseudo-random traffic
    lfsr = 'h1ACE;
    for (int i = 0; i < 2000; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
      lfsr = lfsr & 'hFFFF;
      step(lfsr[0], lfsr[3], lfsr[6] & lfsr[1], W'(lfsr >> 2));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule